// File: doc/BRIEF.md
# Two-Input Upward Merge Node with End-of-Stream Barrier

This block is one internal node of a binary tree that carries packets toward the root. It takes two child streams and produces one parent stream. Each child edge ends in a small bounded queue inside the node. The node moves at most one packet per cycle to the parent. When both children hold ordinary packets, a two-way round-robin arbiter decides which one goes first. The packet that loses waits in its own queue.

Each packet carries a mark bit. A marked packet is an end-of-stream token that closes the current step on that child. Once a token reaches the head of a child queue, that child stops delivering. This keeps the next step's packets behind it, so steps never mix. The other child keeps draining its ordinary packets. When both heads are tokens, the node removes both of them in the same cycle and sends one marked packet to the parent. Because of this, a step boundary travels up the tree with no central control. Every ordinary packet of the step reaches the parent before the combined token.

All streams use valid/ready handshakes, and a transfer happens on a clock edge where both are high. A child may hold its valid high while its ready is low. The packet is not taken and is not lost. The parent output raises valid without waiting for ready. While ready is low, the output keeps valid, data and mark unchanged until the transfer. Reset is synchronous and active high.

Top module: `tok_merge_node`

## Requirements
- R1: While reset is applied and in the cycle after it, out_valid is 0 and both bits of in_ready are 1.
- R2: A packet accepted on an empty, idle node appears on the output in the next cycle. The packets of each child leave in the order that child sent them.
- R3: When both queue heads hold ordinary packets (mark bit 0), the grants alternate between children. Input 0 (bits [DATA_W-1:0] of in_data) is favoured first after reset.
- R4: A token (mark bit 1) at the head of one child produces no output token by itself. The other child's ordinary packets keep flowing past it to the output.
- R5: When both heads are tokens, exactly one output packet with mark 1 is sent, and both tokens are consumed by that single transfer.
- R6: No packet that a child sent after its token reaches the output before the combined token.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_mark hold their values into the next cycle.
- R8: A child queue accepts exactly DEPTH packets while the output is stalled. In that state its in_ready is 0, and a valid offered then is ignored: it never shows up on the output.
- R9: The number of ordinary packets sent before each output token equals the sum of the ordinary packets both children sent before their tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 2 | Per-child packet valid |
| in_ready | output | 2 | Per-child queue has room |
| in_data | input | 2*DATA_W | Child payloads; child c uses bits [c*DATA_W +: DATA_W] |
| in_mark | input | 2 | Per-child token flag (1 = end of stream) |
| out_valid | output | 1 | Parent packet valid |
| out_ready | input | 1 | Parent accepts the packet |
| out_data | output | DATA_W | Parent payload (zero on a token) |
| out_mark | output | 1 | Parent token flag |

## Verification
A child packet goes through one register stage, the queue write. It is visible on the output one cycle after its accepting edge. A combined token is visible one cycle after the later of the two tokens is written, provided no ordinary packet is still waiting. The bench drives on falling edges and records output transfers on rising edges. Each scenario first waits until the expected number of transfers has been recorded and only then compares the order and the counts. Point checks such as the one-cycle latency, the full-queue ready and the stall hold are sampled at the falling edge after the edge that causes them.

// File: rtl/tok_merge_node_pkg.sv
package tok_merge_node_pkg;
  typedef enum logic [1:0] {
    PICK_IDLE  = 2'd0,
    PICK_DATA  = 2'd1,
    PICK_TOKEN = 2'd2
  } pick_e;
endpackage

// File: rtl/tmn_fifo.sv
module tmn_fifo #(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [WORD_W-1:0] push_word,
  output logic              head_valid,
  output logic [WORD_W-1:0] head_word,
  input  logic              pop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [WORD_W-1:0] store [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     level;
  logic              do_push, do_pop;

  assign push_ready = (level != FULL_LVL);
  assign head_valid = (level != '0);
  assign head_word  = store[rd_ptr];
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && head_valid;

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/tmn_rr_arb.sv
module tmn_rr_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         fire,
  input  logic [N-1:0] fired,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;

  always_comb begin
    logic found;
    gnt   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (fire) begin
      for (int k = 0; k < N; k++) begin
        if (fired[k]) ptr <= PW'((k + 1) % N);
      end
    end
  end
endmodule

// File: rtl/tok_merge_node.sv
module tok_merge_node
  import tok_merge_node_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          in_valid,
  output logic [1:0]          in_ready,
  input  logic [2*DATA_W-1:0] in_data,
  input  logic [1:0]          in_mark,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_mark
);
  localparam int NCH    = 2;
  localparam int WORD_W = DATA_W + 1;

  logic [WORD_W-1:0] hd_word [NCH];
  logic [NCH-1:0]    hd_vld, hd_tok, data_req, pop;
  logic [NCH-1:0]    arb_gnt, gnt, lock_gnt;
  logic              lock_q, data_fire, both_tok;
  pick_e             pick;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_child
      tmn_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_q (
        .clk        (clk),
        .rst        (rst),
        .push_valid (in_valid[c]),
        .push_ready (in_ready[c]),
        .push_word  ({in_mark[c], in_data[c*DATA_W +: DATA_W]}),
        .head_valid (hd_vld[c]),
        .head_word  (hd_word[c]),
        .pop        (pop[c])
      );
      assign hd_tok[c]   = hd_vld[c] && hd_word[c][DATA_W];
      assign data_req[c] = hd_vld[c] && !hd_word[c][DATA_W];
    end
  endgenerate

  assign both_tok = &hd_tok;

  tmn_rr_arb #(.N(NCH)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .req   (data_req),
    .fire  (data_fire),
    .fired (gnt),
    .gnt   (arb_gnt)
  );

  assign gnt = lock_q ? lock_gnt : arb_gnt;

  always_comb begin
    if (|data_req)     pick = PICK_DATA;
    else if (both_tok) pick = PICK_TOKEN;
    else               pick = PICK_IDLE;
  end

  assign out_valid = (pick != PICK_IDLE);
  assign out_mark  = (pick == PICK_TOKEN);
  assign data_fire = (pick == PICK_DATA) && out_ready;

  always_comb begin
    out_data = '0;
    if (pick == PICK_DATA) begin
      for (int k = 0; k < NCH; k++) begin
        if (gnt[k]) out_data = hd_word[k][DATA_W-1:0];
      end
    end
  end

  always_comb begin
    pop = '0;
    if (out_ready) begin
      if (pick == PICK_TOKEN)     pop = '1;
      else if (pick == PICK_DATA) pop = gnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= 1'b0;
      lock_gnt <= '0;
    end else begin
      lock_q   <= (pick == PICK_DATA) && !out_ready;
      lock_gnt <= gnt;
    end
  end
endmodule

// File: rtl/tok_merge_node_chk.sv
module tok_merge_node_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        in_valid,
  input logic [1:0]        in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_mark,
  input logic [1:0]        hd_vld,
  input logic [1:0]        hd_tok,
  input logic [1:0]        pop
);
  localparam int CW = $clog2(DEPTH) + 1;
  logic [CW-1:0] occ [2];

  always_ff @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) occ[k] <= '0;
      else occ[k] <= occ[k] + CW'(in_valid[k] && in_ready[k]) - CW'(pop[k] && hd_vld[k]);
    end
  end

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_mark));

  a_r5_token_needs_both: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_mark |-> (hd_tok == 2'b11));

  a_r5_token_pops_pair: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_mark |-> (pop == 2'b11));

  a_r6_data_not_from_token: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_mark |-> $onehot(pop) && ((pop & hd_tok) == 2'b00));

  a_r8_room_means_ready0: assert property (@(posedge clk) disable iff (rst)
    (occ[0] < CW'(DEPTH)) == in_ready[0]);

  a_r8_room_means_ready1: assert property (@(posedge clk) disable iff (rst)
    (occ[1] < CW'(DEPTH)) == in_ready[1]);
endmodule

bind tok_merge_node tok_merge_node_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_mark  (out_mark),
  .hd_vld    (hd_vld),
  .hd_tok    (hd_tok),
  .pop       (pop)
);

// File: tb/test_tok_merge_node.sv
`timescale 1ns/1ps
module test_tok_merge_node;
  localparam int W = 8;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         vld [2];
  logic [W-1:0] dat [2];
  logic         mrk [2];
  logic [1:0]   in_ready;
  logic         out_valid, out_mark, out_ready;
  logic [W-1:0] out_data;
  logic         rdy_mode = 1'b0;
  logic         rdy_force = 1'b0;

  int nchk = 0, nfail = 0, nrec = 0;
  logic [W-1:0] rec_d [4096];
  logic         rec_m [4096];
  bit done = 1'b0;

  always #5 clk = ~clk;

  tok_merge_node #(.DATA_W(W), .DEPTH(D)) i_tok_merge_node (
    .clk(clk), .rst(rst),
    .in_valid({vld[1], vld[0]}), .in_ready(in_ready),
    .in_data({dat[1], dat[0]}), .in_mark({mrk[1], mrk[0]}),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_mark(out_mark)
  );

  initial out_ready = 1'b0;
  always @(negedge clk) out_ready <= rdy_mode ? ~out_ready : rdy_force;

  always @(posedge clk) begin
    if (!rst && out_valid && out_ready && nrec < 4096) begin
      rec_d[nrec] <= out_data;
      rec_m[nrec] <= out_mark;
      nrec <= nrec + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  endtask

  task automatic send(input int s, input logic [W-1:0] d, input logic m);
    @(negedge clk);
    vld[s] = 1'b1; dat[s] = d; mrk[s] = m;
    while (!in_ready[s]) @(negedge clk);
    @(posedge clk);
    #1 vld[s] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rdy_mode = 1'b0; rdy_force = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_recs(input int target);
    for (int t = 0; t < 400 && nrec < target; t++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin vld[i] = 0; dat[i] = '0; mrk[i] = 0; end
    #(10 * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready == 2'b11, "R1 during reset", {out_valid, in_ready}, 3);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready == 2'b11, "R1 after reset", {out_valid, in_ready}, 3);

    // R2 latency: accept at edge k, visible at next falling edge
    @(negedge clk);
    vld[0] = 1; dat[0] = 8'h5A; mrk[0] = 0;
    @(posedge clk); #1 vld[0] = 0;
    @(negedge clk);
    check(out_valid && out_data == 8'h5A && !out_mark, "R2 one-cycle latency", out_data, 'h5A);

    // R3 round robin from reset, with R7 stall hold
    do_reset();
    base = nrec;
    fork
      begin send(0, 8'h10, 0); send(0, 8'h11, 0); end
      begin send(1, 8'h80, 0); send(1, 8'h81, 0); end
    join
    @(negedge clk);
    held = out_data;
    @(negedge clk);
    check(out_valid && out_data == held && held == 8'h10, "R7 hold while stalled", out_data, 'h10);
    rdy_force = 1'b1;
    wait_recs(base + 4);
    check(rec_d[base] == 8'h10, "R3 grant 1", rec_d[base], 'h10);
    check(rec_d[base+1] == 8'h80, "R3 grant 2", rec_d[base+1], 'h80);
    check(rec_d[base+2] == 8'h11, "R3 grant 3", rec_d[base+2], 'h11);
    check(rec_d[base+3] == 8'h81, "R3 grant 4", rec_d[base+3], 'h81);

    // R8 full queue
    do_reset();
    base = nrec;
    for (int k = 0; k < D; k++) send(0, 8'h20 + W'(k), 0);
    @(negedge clk);
    check(in_ready[0] == 1'b0, "R8 ready low when full", in_ready[0], 0);
    vld[0] = 1; dat[0] = 8'hEE; mrk[0] = 0;
    repeat (3) @(negedge clk);
    vld[0] = 0;
    rdy_force = 1'b1;
    wait_recs(base + D);
    repeat (6) @(negedge clk);
    check(nrec - base == D, "R8 accepted count", nrec - base, D);
    for (int k = 0; k < D; k++)
      check(rec_d[base+k] == 8'h20 + W'(k), "R8 content", rec_d[base+k], 'h20 + k);

    // sweep: R2 R4 R5 R6 R9
    for (int mode = 0; mode < 2; mode++) begin
      for (int na = 0; na < 4; na++) begin
        for (int nb = 0; nb < 4; nb++) begin
          int ntok, ndat_before, tokpos, ia, ib, after_ok;
          bit ord_ok;
          do_reset();
          rdy_mode = 1'(mode); rdy_force = 1'b1;
          base = nrec;
          fork
            begin
              for (int k = 0; k < na; k++) send(0, 8'h10 + W'(k), 0);
              send(0, 8'h00, 1);
              send(0, 8'h1F, 0);
            end
            begin
              repeat (2) @(negedge clk);
              for (int k = 0; k < nb; k++) send(1, 8'h80 + W'(k), 0);
              send(1, 8'h00, 1);
              send(1, 8'h8F, 0);
            end
          join
          wait_recs(base + na + nb + 3);
          repeat (4) @(negedge clk);
          ntok = 0; ndat_before = 0; tokpos = -1; ia = 0; ib = 0; after_ok = 0; ord_ok = 1;
          for (int r = base; r < nrec; r++) begin
            if (rec_m[r]) begin
              ntok++;
              if (tokpos < 0) tokpos = r - base;
            end else if (tokpos < 0) begin
              ndat_before++;
              if (rec_d[r] >= 8'h80) begin ord_ok &= (rec_d[r] == 8'h80 + W'(ib)); ib++; end
              else begin ord_ok &= (rec_d[r] == 8'h10 + W'(ia)); ia++; end
            end else if (rec_d[r] == 8'h1F || rec_d[r] == 8'h8F) begin
              after_ok++;
            end
          end
          check(ntok == 1, "R5 one combined token", ntok, 1);
          check(ndat_before == na + nb, "R4 R9 data before token", ndat_before, na + nb);
          check(ord_ok, "R2 per-child order", ord_ok, 1);
          check(after_ok == 2 && nrec - base == na + nb + 3, "R6 next step after token",
                after_ok, 2);
        end
      end
    end
    finish_run();
  end
endmodule